// File: doc/BRIEF.md
# Dual-Mode Watchdog Reset Supervisor

This block merges every reset cause of a processor subsystem into one system reset. Three undervoltage flags arrive from analog comparators that are already digitized: two supply monitors and one auxiliary monitor. An active-low manual-reset request and a kick line driven by the processor are the other two inputs. Every input crosses into the clock domain through a two-flop synchronizer. The output is an active-low reset together with its active-high complement.

While any cause is active, reset is held. Reset is released only after a stretch of `RST_TICKS` system ticks in which no cause has been seen. If a cause returns during the stretch, the count starts again from zero. A tick is a one-cycle enable, and every period is counted in ticks.

The watchdog is cleared and kept idle while reset is asserted. When reset releases, the watchdog starts with a long boot timeout of `LONG_TICKS`. The first kick edge, rising or falling, moves it to the short run timeout of `SHORT_TICKS`. If no edge arrives within the active timeout, the watchdog raises a one-cycle fault, and that fault starts a new reset. Every reset, whatever its cause, returns the watchdog to the long timeout.

Top module: `wdog_supervisor`

## Requirements
- R1: While `por_n` is low, `sys_rst_n` is 0 and `sys_rst` is 1. After `por_n` goes high, the reset is stretched by `RST_TICKS` ticks and released on the clock edge that counts the last of those ticks.
- R2: A 1 on `mon_a_low`, `mon_b_low` or `aux_low` (1 means undervoltage) asserts reset on the third rising clock edge after the input changes. A high level on the input lasting a single cycle is enough.
- R3: `man_rst_n` at 0 asserts reset with the same three-edge latency. Reset stays asserted for as long as the input is low.
- R4: Once every cause has cleared, reset stays asserted for exactly `RST_TICKS` ticks. The count begins two edges after the last cause falls, because of the synchronizer.
- R5: A cause that returns before the stretch has finished restarts the stretch from zero.
- R6: If `kick` shows no edge for `LONG_TICKS` ticks after reset releases, the watchdog faults and reset asserts on the next edge.
- R7: Each edge of `kick`, rising or falling, clears the watchdog count. The first edge switches the watchdog to `SHORT_TICKS`. Going `SHORT_TICKS` ticks without an edge in that mode causes a fault.
- R8: The watchdog is held cleared during reset and resumes in long mode after every reset, including one caused by the watchdog itself.
- R9: No counter advances on a cycle where `tick` is 0.
- R10: `sys_rst` is always the exact complement of `sys_rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tick | input | 1 | One-cycle timebase enable |
| mon_a_low | input | 1 | First supply undervoltage flag (1 = fault), asynchronous |
| mon_b_low | input | 1 | Second supply undervoltage flag (1 = fault), asynchronous |
| aux_low | input | 1 | Auxiliary monitor below threshold (1 = fault), asynchronous |
| man_rst_n | input | 1 | Manual reset request, active low, asynchronous |
| kick | input | 1 | Watchdog kick line toggled by the processor |
| sys_rst_n | output | 1 | System reset, active low |
| sys_rst | output | 1 | System reset, active high |

## Verification
A stretch counter that is off by one moves the release edge of `sys_rst_n` by exactly one cycle. A restart that is missed releases reset too early, within `RST_TICKS` cycles of the recurrence. Watchdog faults show up as a fall of `sys_rst_n` at the wrong time. A mode stuck in long lets a short timeout pass with no reset. A mode stuck in short, or a count not cleared by an edge, produces a reset one timeout after release, long before the boot window ends. The bench therefore predicts the cycle of every edge of `sys_rst_n` and treats any extra edge or any offset edge as a failure.

// File: rtl/wdog_supervisor_pkg.sv
package wdog_supervisor_pkg;

    // Bit positions in the synchronized input bundle
    localparam int SRC_MON_A = 0;
    localparam int SRC_MON_B = 1;
    localparam int SRC_AUX   = 2;
    localparam int SRC_MAN   = 3;
    localparam int SRC_KICK  = 4;
    localparam int SRC_W     = 5;

    // Idle values: no undervoltage, manual request released, kick low
    localparam logic [SRC_W-1:0] SRC_IDLE = 5'b01000;

    typedef enum logic {
        WD_LONG  = 1'b0,
        WD_SHORT = 1'b1
    } wd_mode_e;

endpackage

// File: rtl/wdog_sup_sync.sv
module wdog_sup_sync #(
    parameter int             W      = 1,
    parameter int             STAGES = 2,
    parameter logic [W-1:0]   INIT   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg_q [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            logic [W-1:0] stg_d;
            if (i == 0) begin : g_first
                assign stg_d = d;
            end else begin : g_next
                assign stg_d = stg_q[i-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[i] <= INIT;
                else        stg_q[i] <= stg_d;
            end
        end
    endgenerate

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/wdog_sup_stretch.sv
module wdog_sup_stretch #(
    parameter int RST_TICKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic fault,
    output logic active_o
);

    localparam int             CW   = $clog2(RST_TICKS + 1);
    localparam logic [CW-1:0]  LAST = CW'(RST_TICKS - 1);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fault) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end else if (st_q.active && tick) begin
            if (st_q.cnt == LAST) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.active <= 1'b1;
            st_q.cnt    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;

endmodule

// File: rtl/wdog_sup_watchdog.sv
module wdog_sup_watchdog
    import wdog_supervisor_pkg::*;
#(
    parameter int LONG_TICKS  = 35000,
    parameter int SHORT_TICKS = 1600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hold,
    input  logic kick_s,
    output logic fault_o
);

    localparam int             MAXT       = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
    localparam int             CW         = $clog2(MAXT + 1);
    localparam logic [CW-1:0]  LONG_LAST  = CW'(LONG_TICKS - 1);
    localparam logic [CW-1:0]  SHORT_LAST = CW'(SHORT_TICKS - 1);

    typedef struct packed {
        wd_mode_e      mode;
        logic [CW-1:0] cnt;
        logic          prev;
        logic          fault;
    } st_t;

    st_t           st_d, st_q;
    logic [CW-1:0] limit;
    logic          edge_seen;

    assign limit     = (st_q.mode == WD_LONG) ? LONG_LAST : SHORT_LAST;
    assign edge_seen = kick_s ^ st_q.prev;

    always_comb begin
        st_d       = st_q;
        st_d.prev  = kick_s;
        st_d.fault = 1'b0;
        if (hold) begin
            st_d.cnt  = '0;
            st_d.mode = WD_LONG;
        end else if (edge_seen) begin
            st_d.cnt  = '0;
            st_d.mode = WD_SHORT;
        end else if (tick) begin
            if (st_q.cnt == limit) begin
                st_d.fault = 1'b1;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode  <= WD_LONG;
            st_q.cnt   <= '0;
            st_q.prev  <= 1'b0;
            st_q.fault <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fault_o = st_q.fault;

endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
    import wdog_supervisor_pkg::*;
#(
    parameter int RST_TICKS   = 200,
    parameter int LONG_TICKS  = 35000,
    parameter int SHORT_TICKS = 1600,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic tick,
    input  logic mon_a_low,
    input  logic mon_b_low,
    input  logic aux_low,
    input  logic man_rst_n,
    input  logic kick,
    output logic sys_rst_n,
    output logic sys_rst
);

    logic [SRC_W-1:0] src_raw, src_s;
    logic mon_a_s, mon_b_s, aux_s, man_s, kick_s;
    logic wd_fault, fault_any, rst_active;

    always_comb begin
        src_raw            = '0;
        src_raw[SRC_MON_A] = mon_a_low;
        src_raw[SRC_MON_B] = mon_b_low;
        src_raw[SRC_AUX]   = aux_low;
        src_raw[SRC_MAN]   = man_rst_n;
        src_raw[SRC_KICK]  = kick;
    end

    wdog_sup_sync #(
        .W      (SRC_W),
        .STAGES (SYNC_STAGES),
        .INIT   (SRC_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (por_n),
        .d     (src_raw),
        .q     (src_s)
    );

    assign mon_a_s = src_s[SRC_MON_A];
    assign mon_b_s = src_s[SRC_MON_B];
    assign aux_s   = src_s[SRC_AUX];
    assign man_s   = src_s[SRC_MAN];
    assign kick_s  = src_s[SRC_KICK];

    assign fault_any = mon_a_s | mon_b_s | aux_s | ~man_s | wd_fault;

    wdog_sup_stretch #(
        .RST_TICKS (RST_TICKS)
    ) u_stretch (
        .clk      (clk),
        .rst_n    (por_n),
        .tick     (tick),
        .fault    (fault_any),
        .active_o (rst_active)
    );

    wdog_sup_watchdog #(
        .LONG_TICKS  (LONG_TICKS),
        .SHORT_TICKS (SHORT_TICKS)
    ) u_wdog (
        .clk     (clk),
        .rst_n   (por_n),
        .tick    (tick),
        .hold    (rst_active),
        .kick_s  (kick_s),
        .fault_o (wd_fault)
    );

    assign sys_rst_n = ~rst_active;
    assign sys_rst   = rst_active;

endmodule

// File: rtl/wdog_supervisor_chk.sv
module wdog_supervisor_chk (
    input logic clk,
    input logic por_n,
    input logic tick,
    input logic mon_a_s,
    input logic mon_b_s,
    input logic aux_s,
    input logic man_s,
    input logic wd_fault,
    input logic fault_any,
    input logic sys_rst_n
);

    p_monitor_asserts_r2: assert property (@(posedge clk) disable iff (!por_n)
        (mon_a_s || mon_b_s || aux_s) |=> !sys_rst_n);

    p_manual_holds_r3: assert property (@(posedge clk) disable iff (!por_n)
        !man_s |=> !sys_rst_n);

    p_release_quiet_r4: assert property (@(posedge clk) disable iff (!por_n)
        $rose(sys_rst_n) |-> $past(!fault_any));

    p_wd_trips_r6: assert property (@(posedge clk) disable iff (!por_n)
        wd_fault |=> !sys_rst_n);

    p_release_on_tick_r9: assert property (@(posedge clk) disable iff (!por_n)
        $rose(sys_rst_n) |-> $past(tick));

endmodule

module wdog_sup_wd_chk #(
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          hold,
    input logic          kick_s,
    input logic          long_mode,
    input logic [CW-1:0] cnt,
    input logic          fault
);

    p_hold_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (cnt == '0 && long_mode));

    p_edge_short_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && kick_s != $past(kick_s)) |=> (cnt == '0 && !long_mode));

    p_fault_needs_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> ($past(tick) && $past(!hold)));

    p_idle_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !tick) |=> ($stable(cnt) || cnt == '0));

endmodule

bind wdog_supervisor wdog_supervisor_chk u_sup_chk (
    .clk       (clk),
    .por_n     (por_n),
    .tick      (tick),
    .mon_a_s   (mon_a_s),
    .mon_b_s   (mon_b_s),
    .aux_s     (aux_s),
    .man_s     (man_s),
    .wd_fault  (wd_fault),
    .fault_any (fault_any),
    .sys_rst_n (sys_rst_n)
);

bind wdog_sup_watchdog wdog_sup_wd_chk #(.CW(CW)) u_wd_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .hold      (hold),
    .kick_s    (kick_s),
    .long_mode (st_q.mode == WD_LONG),
    .cnt       (st_q.cnt),
    .fault     (st_q.fault)
);

// File: tb/wdog_supervisor_bench.sv
module wdog_supervisor_bench;

    localparam int R = 6;
    localparam int L = 20;
    localparam int S = 8;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic tick = 1'b1;
    logic mon_a_low = 1'b0, mon_b_low = 1'b0, aux_low = 1'b0;
    logic man_rst_n = 1'b1, kick = 1'b0;
    logic sys_rst_n, sys_rst;

    always #2.5 clk = ~clk;

    wdog_supervisor #(
        .RST_TICKS   (R),
        .LONG_TICKS  (L),
        .SHORT_TICKS (S),
        .SYNC_STAGES (2)
    ) u_wdog_supervisor (
        .clk       (clk),
        .por_n     (por_n),
        .tick      (tick),
        .mon_a_low (mon_a_low),
        .mon_b_low (mon_b_low),
        .aux_low   (aux_low),
        .man_rst_n (man_rst_n),
        .kick      (kick),
        .sys_rst_n (sys_rst_n),
        .sys_rst   (sys_rst)
    );

    typedef struct {
        logic  lvl;
        int    at;
        string tag;
    } exp_t;

    exp_t  sb[$];
    int    cyc = 0;
    int    total = 0;
    int    bad = 0;
    logic  mon_en = 1'b0;
    logic  last_lvl = 1'b0;
    logic  done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    task automatic expect_edge(input logic lvl, input int at, input string tag);
        exp_t e;
        e.lvl = lvl; e.at = at; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // Monitor: every edge of the reset output must match the head of the queue
    always @(negedge clk) begin
        if (mon_en && !done) begin
            chk(sys_rst === ~sys_rst_n, "R10", "complement", int'(sys_rst), int'(~sys_rst_n));
            if (sys_rst_n !== last_lvl) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R4", "unexpected edge at cycle", cyc, -1);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(e.lvl == sys_rst_n, e.tag, "edge level", int'(sys_rst_n), int'(e.lvl));
                    chk(e.at == cyc, e.tag, "edge cycle", cyc, e.at);
                end
                last_lvl = sys_rst_n;
            end
        end
    end

    initial begin
        int k, k2, kr, d;
        step(3);
        chk(sys_rst_n === 1'b0, "R1", "reset state sys_rst_n", int'(sys_rst_n), 0);
        chk(sys_rst === 1'b1, "R1", "reset state sys_rst", int'(sys_rst), 1);
        mon_en = 1'b1;

        // R1 power-up stretch, then R6 long boot timeout, then R8 rearm
        k = cyc; por_n = 1'b1;
        d = k + R;
        expect_edge(1'b1, d, "R1");
        expect_edge(1'b0, d + L + 1, "R6");
        expect_edge(1'b1, d + L + 1 + R, "R8");
        wait_until(d + L + 1 + R);

        // R7 first kick enters short mode, second kick clears, then short timeout
        step(5);
        kick = ~kick;
        step(S - 2);
        k2 = cyc; kick = ~kick;
        expect_edge(1'b0, k2 + S + 4, "R7");
        expect_edge(1'b1, k2 + S + 4 + R, "R7");
        wait_until(k2 + S + 4 + R);

        // R8 after a watchdog reset the long timeout applies again
        step(S + 5);
        kick = ~kick;

        // R3 manual reset held low, released
        step(2);
        k = cyc; man_rst_n = 1'b0;
        expect_edge(1'b0, k + 3, "R3");
        step(30);
        k = cyc; man_rst_n = 1'b1;
        expect_edge(1'b1, k + R + 2, "R3");
        wait_until(k + R + 2);

        // R2 and R5: supply flag, then a recurrence during the stretch
        step(2);
        k = cyc; mon_a_low = 1'b1;
        expect_edge(1'b0, k + 3, "R2");
        step(5);
        mon_a_low = 1'b0;
        step(3);
        mon_b_low = 1'b1;
        step(1);
        k = cyc; mon_b_low = 1'b0;
        expect_edge(1'b1, k + R + 2, "R5");
        wait_until(k + R + 2);

        // R2 single-cycle auxiliary pulse, R4 exact stretch
        step(2);
        k = cyc; aux_low = 1'b1;
        expect_edge(1'b0, k + 3, "R2");
        step(1);
        aux_low = 1'b0;
        expect_edge(1'b1, k + 1 + R + 2, "R4");
        wait_until(k + 1 + R + 2);

        // R9 stretch frozen while tick is low
        step(2);
        k = cyc; mon_a_low = 1'b1;
        expect_edge(1'b0, k + 3, "R2");
        step(5);
        kr = cyc; mon_a_low = 1'b0; tick = 1'b0;
        step(10);
        tick = 1'b1;
        expect_edge(1'b1, kr + 10 + R, "R9");
        wait_until(kr + 10 + R);

        // R6 long timeout once more with no kicks
        d = cyc;
        expect_edge(1'b0, d + L + 1, "R6");
        expect_edge(1'b1, d + L + 1 + R, "R6");
        wait_until(d + L + 1 + R);
        step(3);
        chk(sb.size() == 0, "R4", "pending edges", sb.size(), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog on the bench itself
    always @(posedge clk) begin
        if (!done && cyc > 5000) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL R1 watchdog expired actual=%0d expected=%0d", cyc, 5000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule